// File: doc/BRIEF.md
# Autovectored Interrupt Priority Encoder

This block gathers fourteen interrupt request lines from buffer flag logic and a waveform engine. It holds each request as a sticky pending flag and raises a single interrupt line to a small 8-bit CPU while any flag is pending. When the CPU acknowledges the interrupt, the block records the highest-priority pending source as a vector byte.

The CPU's service entry is a three-byte jump at a fixed address. The jump's high address byte is an ordinary memory byte. The block watches program fetches, and when the CPU reads the low address byte of that jump (address 0x555), it can drive the recorded vector byte in place of the memory data. This lets one jump instruction reach one of fourteen handler slots inside a page. Substitution is governed by an autovector-enable input. With the enable low, every fetched byte passes through unchanged.

Top module: `irq_autovector`

## Requirements
- R1: A rising edge on `srcReq[i]` sets pending flag i. The flag stays set after the request line drops.
- R2: A high `srcClr[i]` clears pending flag i at the next clock edge. A rising edge of the same source in the same cycle wins, and the flag stays set.
- R3: `irqOut` is high exactly while at least one pending flag is set. Reset clears all flags and any recorded vector, so `irqOut` is low after reset.
- R4: Priority is fixed. Index 0 is highest and index 13 is lowest: indices 0-3 are the programmable-level flags of buffers A-D, 4-7 their empty flags, 8-11 their full flags, 12 waveform done, and 13 waveform trigger. The vector byte for index i is 0x80 + 4*i, which gives 0x80 through 0xB4.
- R5: The vector byte is captured in the cycle `intAck` is high while something is pending. A request that becomes pending later does not change the byte that is substituted.
- R6: Substitution happens only for a fetch with `fetchValid` high and `fetchAddr` equal to 0x555, and only after a capture. Any other address, or a cycle with `fetchValid` low, passes `fetchData` through.
- R7: With `autoVecEn` low, `fetchDataOut` always equals `fetchData`.
- R8: One completed fetch at 0x555 uses up the captured vector. A later fetch at 0x555 passes through until the next capture.
- R9: An `intAck` while nothing is pending captures nothing, and no substitution follows.
- R10: Lower-priority sources stay pending while a higher one is served. After the higher one is cleared, the next acknowledge captures the next source in priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | 14 | Source request lines, index 0 highest priority |
| srcClr | input | 14 | Per-source pending clear strobes |
| autoVecEn | input | 1 | Enables vector byte substitution |
| intAck | input | 1 | CPU accepts the interrupt; capture the winner |
| fetchAddr | input | 16 | CPU program fetch address |
| fetchValid | input | 1 | A program fetch is in progress this cycle |
| fetchData | input | 8 | Byte read from program memory |
| fetchDataOut | output | 8 | Byte delivered to the CPU, substituted or passed through |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
The bound assertions check, on every cycle, the rules that depend only on the current and previous port values. A rising request raises `irqOut`. A full clear with no requests drops it. Nothing is substituted with the enable low, with no valid fetch, or at any address other than 0x555. Any substituted byte is a well-formed vector. Only the bench scenarios can show which source wins for each of the fourteen priority positions, that a captured byte holds against a later higher-priority request, that a vector is used only once, that an acknowledge with nothing pending is ignored, and that lower sources are served in order.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  typedef struct packed {
    logic capture;
    logic substitute;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SUB_ADDR = 'h555
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intAck,
  input  logic              anyPending,
  input  logic              autoVecEn,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output ctrlStrobe_t       strobe
);
  typedef enum logic {ST_IDLE, ST_ARMED} vecState_t;

  localparam logic [ADDR_W-1:0] SubAddrL = ADDR_W'(SUB_ADDR);

  vecState_t state, stateNext;
  logic      fetchHit;

  assign fetchHit = fetchValid && (fetchAddr == SubAddrL);

  always_comb begin
    strobe.capture    = intAck && anyPending;
    strobe.substitute = (state == ST_ARMED) && fetchHit && autoVecEn;
    stateNext = state;
    if (strobe.capture)
      stateNext = ST_ARMED;
    else if (state == ST_ARMED && fetchHit)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/irqvec_dp.sv
module irqvec_dp
  import irqvec_pkg::*;
#(
  parameter int NUM_SRC  = 14,
  parameter int DATA_W   = 8,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcClr,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  fetchData,
  output logic [DATA_W-1:0]  fetchDataOut,
  output logic               anyPending
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] pending;
  logic [DATA_W-1:0]  winByte;
  logic [DATA_W-1:0]  heldByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqPrev <= '0;
    else       reqPrev <= srcReq;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    logic riseSeen;
    assign riseSeen = srcReq[i] && !reqPrev[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         pending[i] <= 1'b0;
      else if (riseSeen) pending[i] <= 1'b1;
      else if (srcClr[i]) pending[i] <= 1'b0;
    end
  end

  assign anyPending = |pending;

  always_comb begin
    winByte = DATA_W'(VEC_BASE);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) winByte = DATA_W'(VEC_BASE + VEC_STEP * i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               heldByte <= '0;
    else if (strobe.capture) heldByte <= winByte;
  end

  assign fetchDataOut = strobe.substitute ? heldByte : fetchData;
endmodule

// File: rtl/irq_autovector.sv
module irq_autovector
  import irqvec_pkg::*;
#(
  parameter int NUM_SRC  = 14,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SUB_ADDR = 'h555,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic               autoVecEn,
  input  logic               intAck,
  input  logic [ADDR_W-1:0]  fetchAddr,
  input  logic               fetchValid,
  input  logic [DATA_W-1:0]  fetchData,
  output logic [DATA_W-1:0]  fetchDataOut,
  output logic               irqOut
);
  ctrlStrobe_t strobe;
  logic        anyPending;

  irqvec_ctrl #(.ADDR_W(ADDR_W), .SUB_ADDR(SUB_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .intAck(intAck), .anyPending(anyPending),
    .autoVecEn(autoVecEn), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .strobe(strobe)
  );

  irqvec_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE),
              .VEC_STEP(VEC_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcClr(srcClr),
    .strobe(strobe), .fetchData(fetchData), .fetchDataOut(fetchDataOut),
    .anyPending(anyPending)
  );

  assign irqOut = anyPending;
endmodule

// File: rtl/irqvec_checker.sv
module irqvec_checker #(
  parameter int NUM_SRC  = 14,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SUB_ADDR = 'h555,
  parameter int VEC_BASE = 'h80,
  parameter int VEC_STEP = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [NUM_SRC-1:0] srcClr,
  input logic               autoVecEn,
  input logic [ADDR_W-1:0]  fetchAddr,
  input logic               fetchValid,
  input logic [DATA_W-1:0]  fetchData,
  input logic [DATA_W-1:0]  fetchDataOut,
  input logic               irqOut
);
  localparam logic [DATA_W-1:0] VecLo = DATA_W'(VEC_BASE);
  localparam logic [DATA_W-1:0] VecHi = DATA_W'(VEC_BASE + VEC_STEP * (NUM_SRC - 1));

  AST_RISE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcReq & ~$past(srcReq))) |=> irqOut); // R1

  AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ((&srcClr) && (srcReq == '0)) |=> !irqOut); // R3

  AST_PASS_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !autoVecEn |-> fetchDataOut == fetchData); // R7

  AST_PASS_OFF_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchValid || fetchAddr != ADDR_W'(SUB_ADDR)) |-> fetchDataOut == fetchData); // R6

  AST_VEC_WELL_FORMED: assert property (@(posedge clk) disable iff (!rstN)
    (fetchDataOut != fetchData) |->
      (fetchDataOut >= VecLo && fetchDataOut <= VecHi &&
       ((fetchDataOut - VecLo) % DATA_W'(VEC_STEP)) == '0)); // R4
endmodule

bind irq_autovector irqvec_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .SUB_ADDR(SUB_ADDR), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcClr(srcClr),
  .autoVecEn(autoVecEn), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
  .fetchData(fetchData), .fetchDataOut(fetchDataOut), .irqOut(irqOut)
);

// File: tb/irq_autovector_test.sv
module irq_autovector_test;
  localparam int N = 14;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcReq = '0;
  logic [N-1:0] srcClr = '0;
  logic         autoVecEn = 1'b1;
  logic         intAck = 1'b0;
  logic [15:0]  fetchAddr = 16'h0;
  logic         fetchValid = 1'b0;
  logic [7:0]   fetchData = 8'h00;
  logic [7:0]   fetchDataOut;
  logic         irqOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_autovector uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcClr(srcClr),
    .autoVecEn(autoVecEn), .intAck(intAck), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData),
    .fetchDataOut(fetchDataOut), .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic raise(input logic [N-1:0] mask);
    srcReq = mask;
    tick();
    srcReq = '0;
    tick();
  endtask

  task automatic clearAll();
    srcClr = '1;
    tick();
    srcClr = '0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    tick();
    intAck = 1'b0;
  endtask

  // Combinational probe of the fetch path, then one clock for the fetch to complete.
  task automatic fetch(input logic [15:0] a, input logic v, input logic [7:0] d,
                       input string tag, input int exp);
    fetchAddr = a; fetchValid = v; fetchData = d;
    #1;
    check(tag, fetchDataOut, exp);
    tick();
    fetchValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R3 irq low after reset", irqOut, 0);
    fetch(16'h0555, 1'b1, 8'h11, "R3 no substitution after reset", 8'h11);
  endtask

  task automatic t_sticky();
    srcReq = 14'h0020;
    tick();
    check("R1 pending set on rise", irqOut, 1);
    srcReq = '0;
    tick();
    check("R1 pending sticky after drop", irqOut, 1);
    srcClr = 14'h0020;
    tick();
    srcClr = '0;
    check("R2 clear strobe drops pending", irqOut, 0);
    srcReq = 14'h0008; srcClr = 14'h0008;
    tick();
    srcReq = '0; srcClr = '0;
    tick();
    check("R2 rise wins over clear", irqOut, 1);
    clearAll();
    check("R3 irq low with none pending", irqOut, 0);
  endtask

  task automatic t_priority();
    for (int i = 0; i < N; i++) begin
      raise(N'('1) << i);
      ack();
      fetch(16'h0555, 1'b1, 8'h00, $sformatf("R4 winner index %0d", i), 8'h80 + 4 * i);
      clearAll();
    end
  endtask

  task automatic t_stable();
    raise(14'h0400);
    ack();
    raise(14'h0001);
    fetch(16'h0555, 1'b1, 8'h00, "R5 captured byte held", 8'hA8);
    clearAll();
  endtask

  task automatic t_address();
    raise(14'h0004);
    ack();
    fetch(16'h0554, 1'b1, 8'h05, "R6 high byte passes", 8'h05);
    fetch(16'h0555, 1'b0, 8'h66, "R6 invalid fetch passes", 8'h66);
    fetch(16'h0555, 1'b1, 8'h66, "R6 substituted at 0x555", 8'h88);
    fetch(16'h0555, 1'b1, 8'h77, "R8 vector used once", 8'h77);
    clearAll();
  endtask

  task automatic t_disabled();
    autoVecEn = 1'b0;
    raise(14'h0100);
    ack();
    fetch(16'h0555, 1'b1, 8'h3C, "R7 pass when disabled", 8'h3C);
    autoVecEn = 1'b1;
    clearAll();
  endtask

  task automatic t_noPending();
    ack();
    fetch(16'h0555, 1'b1, 8'h5A, "R9 ack with none pending", 8'h5A);
  endtask

  task automatic t_order();
    raise(14'h0084);
    ack();
    fetch(16'h0555, 1'b1, 8'h00, "R10 first served", 8'h88);
    srcClr = 14'h0004;
    tick();
    srcClr = '0;
    check("R10 lower still pending", irqOut, 1);
    ack();
    fetch(16'h0555, 1'b1, 8'h00, "R10 next in order", 8'h9C);
    clearAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_priority();
    t_stable();
    t_address();
    t_disabled();
    t_noPending();
    t_order();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule